// File: doc/BRIEF.md
# Area-Based External Bus Controller

This block connects a simple internal request interface to an asynchronous external memory or peripheral bus. A 24-bit byte address covers a linear 16 MB space. The top address bits pick one of eight equal 2 MB areas, and the block drives that area's own active-low chip select. External devices therefore need no address decoder of their own.

Each area has its own settings: the external data width (8 or 16 bits), a 2-bit wait-state count, and a wait mode. In automatic mode the programmed waits are the only stretch. In pin mode the programmed waits come first, and the final state then repeats for as long as the external wait input is high. A 16-bit access to an 8-bit area runs as two byte cycles. The requester sees one completion pulse and the assembled halfword.

Requests use valid/ready. `req_ready` is high only while the controller is idle. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. While a cycle is in progress the requester must hold its request, and the controller applies back-pressure by keeping `req_ready` low. Completion is a single-cycle `rsp_valid` pulse with no back-pressure. Area settings are written one area per clock through the `cfg_*` ports. Each access uses the settings its area held on the clock edge that accepted it.

Top module: `ext_bus_ctrl`

## Requirements
- R1: The area index is `req_addr[23:21]`. While a cycle runs, `ext_cs_n[i]` is low only for that area, and at most one chip select is low at any time.
- R2: `req_ready` is high exactly when the controller is idle, and all chip selects are high whenever it is high. A request is accepted on an edge where `req_valid` and `req_ready` are both high.
- R3: In automatic mode, one byte or halfword bus cycle lasts 2 + W clocks with chip select low, where W is the area's 2-bit wait count (0 to 3). The wait input has no effect on its length.
- R4: In pin mode, a bus cycle lasts 2 + W + K clocks. K is the number of consecutive clocks that `ext_wait` is high, sampled from the clock after the W programmed waits. `ext_wait` is ignored during the first state and during the programmed waits.
- R5: A 16-bit access (`req_wide`=1) to a 16-bit area is one bus cycle, with `ext_addr[0]` forced to 0. The full 16-bit lane is used, and bits [15:8] carry the byte at the even address.
- R6: A 16-bit access to an 8-bit area is two byte cycles on lane [7:0]. The even address goes first and carries data bits [15:8]; the odd address follows and carries bits [7:0]. All chip selects are high for one clock between the two cycles, and only one completion pulse is produced. The total time is 2·(2+W+K)+1 clocks.
- R7: A byte access (`req_wide`=0) is one bus cycle at the exact address on lane [7:0]. `rsp_rdata[15:8]` returns 0, and `ext_dout[15:8]` is 0 during byte writes.
- R8: Read data is taken from `ext_din` only on the last clock of the final bus state. Values present on earlier clocks of the cycle have no effect.
- R9: `rsp_valid` is high for exactly one clock, in the clock after the last bus state. All chip selects are high for at least one clock between accesses.
- R10: After reset, every area is set to 8-bit width, 3 waits and automatic mode.
- R11: `ext_rd_n` is low for the whole of a read cycle. `ext_wr_n` is low from the second state to the end of a write cycle, and `ext_dout` holds the write data while it is low. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write settings for one area this clock |
| cfg_area | input | 3 | Area whose settings are written |
| cfg_wait_pin | input | 1 | 1 = pin wait mode, 0 = automatic |
| cfg_waits | input | 2 | Programmed wait states |
| cfg_bus16 | input | 1 | 1 = 16-bit area, 0 = 8-bit area |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data |
| ext_addr | output | 24 | External address |
| ext_cs_n | output | 8 | Per-area chip selects, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_dout | output | 16 | Write data to the external bus |
| ext_oe | output | 1 | Enable for the write data drivers |
| ext_din | input | 16 | Read data from the external bus |
| ext_wait | input | 1 | External wait request, active high |

## Verification
Counting from the accepting edge, `rsp_valid` is due after exactly 2+W+K edges for a single cycle and after 2·(2+W+K)+1 edges for a split access. The bench counts falling edges from acceptance and compares that count with the formula. It reads `rsp_rdata` on the falling edge where the pulse is seen, and it confirms the pulse is gone one falling edge later. The bench's external device model raises `ext_wait` and presents valid read data according to how many clocks the chip select has been low. Because its data is garbage until the final state, any sampling that comes early or late shows up as a data mismatch. Write strobes are logged when `ext_wr_n` rises and are compared one clock after the completion pulse.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int WAIT_W = 2;

  typedef struct packed {
    logic              pin_wait;
    logic [WAIT_W-1:0] waits;
    logic              bus16;
  } area_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_T1,
    S_TW,
    S_T2,
    S_GAP
  } bus_state_e;

  localparam area_cfg_t CFG_RESET = '{pin_wait: 1'b0, waits: '1, bus16: 1'b0};
endpackage

// File: rtl/ebc_cfg_bank.sv
module ebc_cfg_bank
  import ebc_pkg::*;
#(
  parameter int N_AREAS = 8,
  localparam int AW = $clog2(N_AREAS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  area_cfg_t     wr_cfg,
  input  logic [AW-1:0] rd_idx,
  output area_cfg_t     rd_cfg
);
  area_cfg_t cfg_q [N_AREAS];

  for (genvar g = 0; g < N_AREAS; g++) begin : g_area
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[g] <= CFG_RESET;
      else if (wr_en && wr_idx == AW'(g)) cfg_q[g] <= wr_cfg;
    end
  end

  assign rd_cfg = cfg_q[rd_idx];
endmodule

// File: rtl/ebc_area_dec.sv
module ebc_area_dec #(
  parameter int ADDR_W  = 24,
  parameter int N_AREAS = 8,
  localparam int AW = $clog2(N_AREAS)
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               en,
  output logic [N_AREAS-1:0] cs_n
);
  logic [AW-1:0] area;
  assign area = addr[ADDR_W-1 -: AW];

  for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
    assign cs_n[g] = ~(en && area == AW'(g));
  end
endmodule

// File: rtl/ebc_cycle_seq.sv
module ebc_cycle_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  area_cfg_t         req_cfg,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_wait
);
  bus_state_e        st_q;
  area_cfg_t         cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q, wide_q, split_q, half_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic              accept, t2_done;

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign t2_done   = (st_q == S_T2) && !(cfg_q.pin_wait && bus_wait);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cfg_q     <= CFG_RESET;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      wide_q    <= 1'b0;
      split_q   <= 1'b0;
      half_q    <= 1'b0;
      wcnt_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          st_q    <= S_T1;
          cfg_q   <= req_cfg;
          addr_q  <= req_wide ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
          wdata_q <= req_wdata;
          write_q <= req_write;
          wide_q  <= req_wide;
          split_q <= req_wide && !req_cfg.bus16;
          half_q  <= 1'b0;
          wcnt_q  <= req_cfg.waits;
        end
        S_T1: st_q <= (wcnt_q != '0) ? S_TW : S_T2;
        S_TW: begin
          wcnt_q <= wcnt_q - 1'b1;
          if (wcnt_q == WAIT_W'(1)) st_q <= S_T2;
        end
        S_T2: if (t2_done) begin
          if (!write_q) begin
            if (split_q && !half_q)
              rsp_rdata[DATA_W-1:BYTE_W] <= bus_din[BYTE_W-1:0];
            else if (split_q)
              rsp_rdata[BYTE_W-1:0] <= bus_din[BYTE_W-1:0];
            else if (wide_q)
              rsp_rdata <= bus_din;
            else
              rsp_rdata <= {{BYTE_W{1'b0}}, bus_din[BYTE_W-1:0]};
          end
          if (split_q && !half_q) begin
            st_q      <= S_GAP;
            half_q    <= 1'b1;
            addr_q[0] <= 1'b1;
            wcnt_q    <= cfg_q.waits;
          end else begin
            st_q      <= S_IDLE;
            rsp_valid <= 1'b1;
          end
        end
        S_GAP:   st_q <= S_T1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_en   = (st_q == S_T1) || (st_q == S_TW) || (st_q == S_T2);
    bus_addr = addr_q;
    bus_rd_n = !(bus_en && !write_q);
    bus_wr_n = !(write_q && (st_q == S_TW || st_q == S_T2));
    bus_oe   = bus_en && write_q;
    if (split_q)
      bus_dout = {{BYTE_W{1'b0}}, half_q ? wdata_q[BYTE_W-1:0] : wdata_q[DATA_W-1:BYTE_W]};
    else if (wide_q)
      bus_dout = wdata_q;
    else
      bus_dout = {{BYTE_W{1'b0}}, wdata_q[BYTE_W-1:0]};
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int N_AREAS = 8,
  localparam int AW = $clog2(N_AREAS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_area,
  input  logic               cfg_wait_pin,
  input  logic [WAIT_W-1:0]  cfg_waits,
  input  logic               cfg_bus16,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_wide,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic [N_AREAS-1:0] ext_cs_n,
  output logic               ext_rd_n,
  output logic               ext_wr_n,
  output logic [DATA_W-1:0]  ext_dout,
  output logic               ext_oe,
  input  logic [DATA_W-1:0]  ext_din,
  input  logic               ext_wait
);
  area_cfg_t wr_cfg, req_cfg;
  logic      bus_en;

  assign wr_cfg = '{pin_wait: cfg_wait_pin, waits: cfg_waits, bus16: cfg_bus16};

  ebc_cfg_bank #(.N_AREAS(N_AREAS)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_area),
    .wr_cfg (wr_cfg),
    .rd_idx (req_addr[ADDR_W-1 -: AW]),
    .rd_cfg (req_cfg)
  );

  ebc_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_wide  (req_wide),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_cfg   (req_cfg),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .bus_en    (bus_en),
    .bus_addr  (ext_addr),
    .bus_rd_n  (ext_rd_n),
    .bus_wr_n  (ext_wr_n),
    .bus_dout  (ext_dout),
    .bus_oe    (ext_oe),
    .bus_din   (ext_din),
    .bus_wait  (ext_wait)
  );

  ebc_area_dec #(.ADDR_W(ADDR_W), .N_AREAS(N_AREAS)) u_dec (
    .addr (ext_addr),
    .en   (bus_en),
    .cs_n (ext_cs_n)
  );
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int ADDR_W  = 24,
  parameter int N_AREAS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [ADDR_W-1:0]  ext_addr,
  input logic [N_AREAS-1:0] ext_cs_n,
  input logic               ext_rd_n,
  input logic               ext_wr_n
);
  a_r1_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  a_r1_strobe_has_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> !(&ext_cs_n));

  a_r2_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&ext_cs_n));

  a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ext_cs_n) && !(&$past(ext_cs_n))) |-> $stable(ext_addr));

  a_r9_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&ext_cs_n));

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));
endmodule

bind ext_bus_ctrl ebc_checker #(.ADDR_W(ADDR_W), .N_AREAS(N_AREAS)) u_ebc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ext_addr  (ext_addr),
  .ext_cs_n  (ext_cs_n),
  .ext_rd_n  (ext_rd_n),
  .ext_wr_n  (ext_wr_n)
);

// File: tb/test_ext_bus_ctrl.sv
`timescale 1ns/1ps
module test_ext_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_area = '0;
  logic        cfg_wait_pin = 1'b0;
  logic [1:0]  cfg_waits = '0;
  logic        cfg_bus16 = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [23:0] ext_addr;
  logic [7:0]  ext_cs_n;
  logic        ext_rd_n, ext_wr_n, ext_oe;
  logic [15:0] ext_dout;
  logic [15:0] ext_din;
  logic        ext_wait;

  int tests = 0;
  int fails = 0;

  // bench mirror of area settings (reset values per R10)
  logic       m_pin  [8];
  logic [1:0] m_w    [8];
  logic       m_wide [8];
  int         kpin = 0;
  logic       force_wait = 1'b0;
  logic       cur_wide = 1'b0;
  logic [2:0] exp_area = '0;
  int         cnt = 0;
  int         cs_cycles = 0;
  logic [7:0] prev_cs = 8'hFF;

  logic [23:0] wl_a [4];
  logic [15:0] wl_d [4];
  int          wl_n = 0;
  logic [23:0] cur_a = '0;
  logic [15:0] cur_d = '0;
  logic        wr_act = 1'b0;

  ext_bus_ctrl i_ext_bus_ctrl (.*);

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // external device model: wait and valid data depend on clocks of chip select
  always @(posedge clk) cnt <= (&ext_cs_n) ? 0 : cnt + 1;

  always_comb begin
    automatic logic [2:0] ar = ext_addr[23:21];
    automatic int         last = 1 + int'(m_w[ar]) + (m_pin[ar] ? kpin : 0);
    ext_wait = m_pin[ar] ? (cnt < last) : force_wait;
    if (cnt >= last) begin
      if (m_wide[ar] && cur_wide)
        ext_din = {pat({ext_addr[23:1], 1'b0}), pat({ext_addr[23:1], 1'b1})};
      else
        ext_din = {8'hEE, pat(ext_addr)};
    end else begin
      ext_din = 16'hC3A5 ^ 16'(cnt);
    end
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!(&ext_cs_n)) begin
        cs_cycles = cs_cycles + 1;
        if (ext_cs_n != ~(8'b1 << exp_area)) begin
          fails = fails + 1;
          $display("FAIL R1 cs_n actual=%b expected=%b", ext_cs_n, ~(8'b1 << exp_area));
        end
        if (!(&prev_cs) && prev_cs != ext_cs_n) begin
          fails = fails + 1;
          $display("FAIL R9 cs changed without gap actual=%b expected=%b", ext_cs_n, prev_cs);
        end
      end
      prev_cs = ext_cs_n;
      if (!ext_wr_n) begin
        cur_a = ext_addr; cur_d = ext_dout; wr_act = 1'b1;
      end else if (wr_act) begin
        if (wl_n < 4) begin wl_a[wl_n] = cur_a; wl_d[wl_n] = cur_d; end
        wl_n = wl_n + 1;
        wr_act = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] a, input logic pin, input logic [1:0] w, input logic b16);
    @(negedge clk);
    cfg_we = 1'b1; cfg_area = a; cfg_wait_pin = pin; cfg_waits = w; cfg_bus16 = b16;
    @(negedge clk);
    cfg_we = 1'b0;
    m_pin[a] = pin; m_w[a] = w; m_wide[a] = b16;
  endtask

  task automatic txn(input logic [2:0] ar, input logic [20:0] low, input logic wr,
                     input logic wide, input int k, input logic fw, input logic [15:0] wd);
    logic [23:0] a, ae;
    int lat, nb, per, exp_lat;
    bit ready_ok;
    logic split;
    a = {ar, low};
    ae = {a[23:1], 1'b0};
    split = wide && !m_wide[ar];
    nb = split ? 2 : 1;
    per = 2 + int'(m_w[ar]) + (m_pin[ar] ? k : 0);
    exp_lat = nb * per + (split ? 1 : 0);
    @(negedge clk);
    kpin = k; force_wait = fw; cur_wide = wide; exp_area = ar;
    wl_n = 0; cs_cycles = 0;
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = $urandom;
    lat = 0;
    ready_ok = 1'b1;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) ready_ok = 1'b0;
      @(negedge clk);
      lat = lat + 1;
    end
    // R3 R4 R6: completion timing
    check(lat == exp_lat, m_pin[ar] ? "R4 latency" : "R3 latency", lat, exp_lat);
    check(cs_cycles == nb * per, "R1 cs low clocks", cs_cycles, nb * per);
    check(ready_ok, "R2 ready low while busy", 0, 1);
    if (!wr) begin
      logic [15:0] er;
      er = wide ? {pat(ae), pat({ae[23:1], 1'b1})} : {8'h00, pat(a)};
      check(rsp_rdata == er, wide ? (split ? "R6 R8 read" : "R5 R8 read") : "R7 R8 read",
            rsp_rdata, er);
    end
    @(negedge clk);
    check(!rsp_valid, "R9 done single clock", rsp_valid, 0);
    if (wr) begin
      if (split) begin
        check(wl_n == 2, "R6 write strobes", wl_n, 2);
        check(wl_a[0] == ae && wl_d[0] == {8'h00, wd[15:8]}, "R6 first half",
              {wl_a[0][15:0], wl_d[0]}, {ae[15:0], 8'h00, wd[15:8]});
        check(wl_a[1] == {ae[23:1], 1'b1} && wl_d[1] == {8'h00, wd[7:0]}, "R6 second half",
              {wl_a[1][15:0], wl_d[1]}, {ae[15:1], 1'b1, 8'h00, wd[7:0]});
      end else begin
        logic [23:0] xa;
        logic [15:0] xd;
        xa = wide ? ae : a;
        xd = wide ? wd : {8'h00, wd[7:0]};
        check(wl_n == 1 && wl_a[0] == xa && wl_d[0] == xd, wide ? "R5 R11 write" : "R7 R11 write",
              {wl_a[0][15:0], wl_d[0]}, {xa[15:0], xd});
      end
    end else begin
      check(wl_n == 0, "R11 no write strobe on read", wl_n, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_pin[i] = 1'b0; m_w[i] = 2'd3; m_wide[i] = 1'b0; end
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check(&ext_cs_n && ext_rd_n && ext_wr_n && !rsp_valid, "R2 reset bus idle",
          {ext_cs_n, ext_rd_n, ext_wr_n, rsp_valid}, 32'h7FE);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R2 ready after reset", req_ready, 1);
    // R10: reset settings, 8-bit, 3 waits, automatic; wait input ignored
    txn(3'd5, 21'h01234, 1'b0, 1'b0, 0, 1'b1, 16'h0);
    txn(3'd5, 21'h01234, 1'b0, 1'b1, 0, 1'b1, 16'h0);
    // directed corners
    set_cfg(3'd0, 1'b0, 2'd0, 1'b1);
    txn(3'd0, 21'h00011, 1'b0, 1'b1, 0, 1'b0, 16'h0);
    txn(3'd0, 21'h00020, 1'b1, 1'b1, 0, 1'b0, 16'hBEEF);
    txn(3'd0, 21'h00021, 1'b0, 1'b0, 0, 1'b0, 16'h0);
    set_cfg(3'd7, 1'b1, 2'd0, 1'b0);
    txn(3'd7, 21'h1FFFFE, 1'b0, 1'b1, 3, 1'b0, 16'h0);
    txn(3'd7, 21'h000007, 1'b1, 1'b1, 2, 1'b0, 16'hA55A);
    set_cfg(3'd2, 1'b1, 2'd3, 1'b1);
    txn(3'd2, 21'h00400, 1'b0, 1'b1, 2, 1'b0, 16'h0);
    txn(3'd2, 21'h00401, 1'b1, 1'b0, 0, 1'b0, 16'h12C4);
    // random
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 7) == 0)
        set_cfg(3'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
      txn(3'($urandom), 21'($urandom), 1'($urandom), 1'($urandom),
          $urandom_range(0, 3), 1'($urandom), 16'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    tests = tests + 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule